// File: doc/BRIEF.md
# HDLC Receive Deframer with Service-Identifier Filter

This block recovers HDLC frames from a serial bit stream that arrives one bit per clock-enable strobe. It finds the opening and closing flags and strips the zeros the sender inserted after runs of five ones. It checks the 16-bit frame check sequence and spots abort and idle conditions on the line. Frames too short to carry a check sequence are dropped without a trace. An optional filter keeps or discards a frame according to the service identifier held in the upper six bits of its first byte.

Frames that are kept leave the block as a byte stream. Each payload byte is one beat marked valid, and the two check-sequence bytes are never forwarded. One final beat, marked last, carries the status of the frame. A separate idle output reports a long run of ones on the line. Filter enables and the match policy are static configuration inputs. A ready input from the consumer is sampled only to flag overflow; it never stalls the receiver.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The bit pattern 0,1,1,1,1,1,1,0 is a flag. It closes the current frame and opens the next one, so a single flag may serve as both. Each payload byte appears as one beat with out_valid=1 and out_last=0, in arrival order, one clock after the strobe that completes the byte two positions later in the frame.
- R2: Within a frame, a zero that follows five consecutive ones is removed. Bits of each byte arrive least significant bit first.
- R3: After the last payload byte of a kept frame, exactly one beat follows with out_last=1 and a status byte: bit 0 aborted, bit 1 check-sequence error, bit 2 overflow, bits 7:3 zero. The two check-sequence bytes are never output.
- R4: The check sequence is computed over every frame byte, check bytes included. The register starts at 0xFFFF and uses the generator x^16+x^12+x^5+1, processed bit-reflected (0x8408). A frame that does not leave the residue 0xF0B8, or whose bit count is not a multiple of eight, gets status bit 1 set.
- R5: Seven consecutive ones inside a frame abort it. If the frame has already put out beats, its status beat has bit 0 set. The receiver then ignores the line until the next flag.
- R6: The idle output rises one clock after the strobe of the IDLE_RUN-th consecutive one (15 by default). It stays low after fewer ones and drops after the strobe of a zero. It never sets any status bit.
- R7: A frame with fewer than three bytes between its flags, check bytes included, produces no beat at all.
- R8: cfg_sapi_en bit 0 compares the first byte's bits 7:2 with 63, bit 1 compares them with 0, and bit 2 compares them with 16. With any enable set, a frame is kept on a match when cfg_reject_on_match=0, and kept on no match when cfg_reject_on_match=1. A frame that is not kept produces no beat.
- R9: With cfg_sapi_en all zero, every frame is kept, regardless of cfg_reject_on_match.
- R10: Status bit 2 is set when out_ready was low at the strobe that completed any byte whose beat the frame put out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Strobe: bit_in is taken on this clock |
| bit_in | input | 1 | Serial line bit |
| cfg_sapi_en | input | 3 | Compare enables: bit 0 value 63, bit 1 value 0, bit 2 value 16 |
| cfg_reject_on_match | input | 1 | Match policy: 0 keeps matching frames, 1 discards them |
| out_ready | input | 1 | Consumer ready, sampled for the overflow flag |
| out_valid | output | 1 | Beat valid |
| out_data | output | 8 | Payload byte, or status byte on the last beat |
| out_last | output | 1 | Marks the status beat of a frame |
| idle | output | 1 | Long run of ones on the line |

## Verification
The bench builds the block with the default IDLE_RUN of 15. This makes the idle boundary reachable with a 14- and 15-one run after a flag, and it keeps the abort point at the seventh one well apart from it. The bench inserts random gaps between strobes. It sends frames of 0 to 11 payload bytes, which cover the two-byte holdback, frames just under and at the three-byte minimum, shared flags, and aborts that land while the last byte is still in flight. Filter settings, the match policy, ready and corrupted check bytes are varied from frame to frame.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W     = 8;
  localparam int FCS_BYTES  = 2;
  localparam int MIN_BYTES  = FCS_BYTES + 1;
  localparam int FLAG_RUN   = 6;
  localparam int DLY_BITS   = FLAG_RUN + 1;

  localparam logic [15:0] CRC_INIT    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_RV = 16'h8408;
  localparam logic [15:0] CRC_GOOD    = 16'hF0B8;

  localparam logic [5:0] SAPI_GROUP = 6'd63;
  localparam logic [5:0] SAPI_SIG   = 6'd0;
  localparam logic [5:0] SAPI_PKT   = 6'd16;

  localparam int ST_ABORT = 0;
  localparam int ST_CRC   = 1;
  localparam int ST_OVF   = 2;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_step = (c >> 1) ^ (fb ? CRC_POLY_RV : 16'h0000);
  endfunction
endpackage

// File: rtl/hdlc_bit_sync.sv
module hdlc_bit_sync
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic flag_hit,
  output logic abort_hit,
  output logic close_hit,
  output logic dbit_vld,
  output logic dbit,
  output logic idle
);
  localparam int RUN_W  = $clog2(IDLE_RUN + 1);
  localparam int FILL_W = $clog2(DLY_BITS + 1);

  logic [RUN_W-1:0]    run_q, run_d;
  logic                in_frame_q, in_frame_d;
  logic [DLY_BITS-1:0] dly_q, dly_d;
  logic [FILL_W-1:0]   fill_q, fill_d;
  logic                idle_q, idle_d;
  logic                stuff_hit, pass, run_at_flag;

  always_comb begin
    run_at_flag = (run_q == RUN_W'(FLAG_RUN));
    flag_hit    = bit_en && !bit_in && run_at_flag;
    abort_hit   = bit_en && bit_in && run_at_flag && in_frame_q;
    close_hit   = flag_hit && in_frame_q;
    stuff_hit   = bit_en && !bit_in && (run_q == RUN_W'(FLAG_RUN - 1));
    pass        = bit_en && in_frame_q && !flag_hit && !abort_hit && !stuff_hit;
    dbit_vld    = pass && (fill_q == FILL_W'(DLY_BITS));
    dbit        = dly_q[DLY_BITS-1];

    run_d = run_q;
    if (bit_en) begin
      if (!bit_in)                          run_d = '0;
      else if (run_q != RUN_W'(IDLE_RUN))   run_d = run_q + 1'b1;
    end
    in_frame_d = flag_hit ? 1'b1 : (abort_hit ? 1'b0 : in_frame_q);
    dly_d      = pass ? {dly_q[DLY_BITS-2:0], bit_in} : dly_q;
    fill_d     = fill_q;
    if (flag_hit || abort_hit)                     fill_d = '0;
    else if (pass && fill_q != FILL_W'(DLY_BITS))  fill_d = fill_q + 1'b1;
    idle_d = (run_d == RUN_W'(IDLE_RUN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      in_frame_q <= 1'b0;
      dly_q      <= '0;
      fill_q     <= '0;
      idle_q     <= 1'b0;
    end else begin
      run_q      <= run_d;
      in_frame_q <= in_frame_d;
      dly_q      <= dly_d;
      fill_q     <= fill_d;
      idle_q     <= idle_d;
    end
  end

  assign idle = idle_q;

  // R6
  idle_frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> !in_frame_q);
endmodule

// File: rtl/hdlc_byte_asm.sv
module hdlc_byte_asm
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              dbit_vld,
  input  logic              dbit,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              crc_ok,
  output logic              aligned
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] sr_q, sr_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [15:0]       crc_q, crc_d;

  always_comb begin
    byte_done = dbit_vld && (bcnt_q == CNT_W'(BYTE_W - 1));
    byte_val  = {dbit, sr_q};
    crc_ok    = (crc_q == CRC_GOOD);
    aligned   = (bcnt_q == '0);

    sr_d   = sr_q;
    bcnt_d = bcnt_q;
    crc_d  = crc_q;
    if (clr) begin
      bcnt_d = '0;
      crc_d  = CRC_INIT;
    end else if (dbit_vld) begin
      sr_d   = {dbit, sr_q[BYTE_W-2:1]};
      bcnt_d = bcnt_q + 1'b1;
      crc_d  = crc_step(crc_q, dbit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bcnt_q <= '0;
      crc_q  <= CRC_INIT;
    end else begin
      sr_q   <= sr_d;
      bcnt_q <= bcnt_d;
      crc_q  <= crc_d;
    end
  end

  // R1
  clr_bit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !dbit_vld);
endmodule

// File: rtl/hdlc_frame_ctl.sv
module hdlc_frame_ctl
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_evt,
  input  logic              close_evt,
  input  logic              abort_evt,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              crc_ok,
  input  logic              aligned,
  input  logic [2:0]        cfg_sapi_en,
  input  logic              cfg_reject_on_match,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  localparam int CNT_W = $clog2(MIN_BYTES + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] h0_q, h0_d, h1_q, h1_d;
  logic              acc_q, acc_d, ovf_q, ovf_d;
  logic              ov_q, ov_d, ol_q, ol_d;
  logic [BYTE_W-1:0] od_q, od_d;
  logic [5:0]        sapi;
  logic              match, acc_now, emit_data, emit_stat;
  logic [BYTE_W-1:0] status;

  always_comb begin
    sapi    = byte_val[BYTE_W-1:2];
    match   = (cfg_sapi_en[0] && sapi == SAPI_GROUP) ||
              (cfg_sapi_en[1] && sapi == SAPI_SIG) ||
              (cfg_sapi_en[2] && sapi == SAPI_PKT);
    acc_now = (cfg_sapi_en == 3'b000) || (match ^ cfg_reject_on_match);

    emit_data = byte_done && acc_q && (cnt_q >= CNT_W'(FCS_BYTES));
    emit_stat = (close_evt || abort_evt) && acc_q && (cnt_q == CNT_W'(MIN_BYTES));
    status           = '0;
    status[ST_ABORT] = abort_evt;
    status[ST_CRC]   = close_evt && (!crc_ok || !aligned);
    status[ST_OVF]   = ovf_q;

    cnt_d = cnt_q;
    h0_d  = h0_q;
    h1_d  = h1_q;
    acc_d = acc_q;
    ovf_d = ovf_q;
    if (open_evt || abort_evt) begin
      cnt_d = '0;
      acc_d = 1'b1;
      ovf_d = 1'b0;
    end else if (byte_done) begin
      if (cnt_q != CNT_W'(MIN_BYTES)) cnt_d = cnt_q + 1'b1;
      h0_d = h1_q;
      h1_d = byte_val;
      if (cnt_q == '0) acc_d = acc_now;
      if (emit_data && !out_ready) ovf_d = 1'b1;
    end

    ov_d = emit_data || emit_stat;
    ol_d = emit_stat;
    od_d = emit_stat ? status : (emit_data ? h0_q : od_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      h0_q  <= '0;
      h1_q  <= '0;
      acc_q <= 1'b1;
      ovf_q <= 1'b0;
      ov_q  <= 1'b0;
      ol_q  <= 1'b0;
      od_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      h0_q  <= h0_d;
      h1_q  <= h1_d;
      acc_q <= acc_d;
      ovf_q <= ovf_d;
      ov_q  <= ov_d;
      ol_q  <= ol_d;
      od_q  <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_data  = od_q;

  // R1
  byte_end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !(close_evt || abort_evt));
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic [2:0]        cfg_sapi_en,
  input  logic              cfg_reject_on_match,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              idle
);
  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              flag_hit, abort_hit, close_hit, dbit_vld, dbit;
  logic              byte_done, crc_ok, aligned;
  logic [BYTE_W-1:0] byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  hdlc_bit_sync #(.IDLE_RUN(IDLE_RUN)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .bit_en(bit_en), .bit_in(bit_in),
    .flag_hit(flag_hit), .abort_hit(abort_hit), .close_hit(close_hit),
    .dbit_vld(dbit_vld), .dbit(dbit), .idle(idle)
  );

  hdlc_byte_asm u_asm (
    .clk(clk), .rst_n(rst_i_n), .clr(flag_hit || abort_hit),
    .dbit_vld(dbit_vld), .dbit(dbit), .byte_done(byte_done),
    .byte_val(byte_val), .crc_ok(crc_ok), .aligned(aligned)
  );

  hdlc_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_i_n), .open_evt(flag_hit), .close_evt(close_hit),
    .abort_evt(abort_hit), .byte_done(byte_done), .byte_val(byte_val),
    .crc_ok(crc_ok), .aligned(aligned), .cfg_sapi_en(cfg_sapi_en),
    .cfg_reject_on_match(cfg_reject_on_match), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  // R6
  idle_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    idle |-> !out_valid);
endmodule

// File: tb/hdlc_rx_deframer_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [2:0] cfg_sapi_en = 3'b000;
  logic       cfg_reject_on_match = 1'b0;
  logic       out_ready = 1'b1;
  logic       out_valid, out_last, idle;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  hdlc_rx_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .cfg_sapi_en(cfg_sapi_en), .cfg_reject_on_match(cfg_reject_on_match),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .idle(idle)
  );

  int n_checks = 0, n_fails = 0;
  int wr = 0, rd = 0;
  logic [7:0] exp_d [0:1023];
  logic       exp_l [0:1023];
  string      exp_t [0:1023];
  string      cur_tag = "R1";
  logic [7:0] fb [0:63];
  int  ones_run = 0;
  bit  gap_en = 0;
  bit  mon_en = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic last, input logic [7:0] d);
    exp_d[wr] = d; exp_l[wr] = last; exp_t[wr] = cur_tag; wr++;
  endtask

  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      n_checks++;
      if (rd >= wr) begin
        n_fails++;
        $display("FAIL %s: unexpected beat actual last=%0b data=%02h expected no beat",
                 cur_tag, out_last, out_data);
      end else begin
        if (out_last !== exp_l[rd] || out_data !== exp_d[rd]) begin
          n_fails++;
          $display("FAIL %s: beat %0d actual last=%0b data=%02h expected last=%0b data=%02h",
                   exp_t[rd], rd, out_last, out_data, exp_l[rd], exp_d[rd]);
        end
        rd++;
      end
    end
  end

  task automatic send_bit(input bit b);
    int g;
    g = gap_en ? int'($urandom % 3) : 0;
    repeat (g) begin @(posedge clk); #2; end
    bit_en = 1'b1; bit_in = b;
    @(posedge clk); #2;
    bit_en = 1'b0;
  endtask

  task automatic send_data_bit(input bit b);
    send_bit(b);
    if (b) begin
      ones_run++;
      if (ones_run == 5) begin send_bit(1'b0); ones_run = 0; end
    end else ones_run = 0;
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    repeat (6) send_bit(1'b1);
    send_bit(1'b0);
    ones_run = 0;
  endtask

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) send_data_bit(fb[i][k]);
  endtask

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c;
    logic fbit;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        fbit = c[0] ^ fb[i][k];
        c = c >> 1;
        if (fbit) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  function automatic bit keep_f(input logic [7:0] b);
    bit m;
    m = (cfg_sapi_en[0] && b[7:2] == 6'd63) || (cfg_sapi_en[1] && b[7:2] == 6'd0) ||
        (cfg_sapi_en[2] && b[7:2] == 6'd16);
    if (cfg_sapi_en == 3'b000) return 1'b1;
    return m ^ cfg_reject_on_match;
  endfunction

  // payload already in fb[0..n-1]
  task automatic run_frame(input int n, input bit corrupt, input bit open_flag);
    logic [15:0] f;
    f = fcs_of(n);
    fb[n] = f[7:0] ^ (corrupt ? 8'h01 : 8'h00);
    fb[n+1] = f[15:8];
    if (n + 2 >= 3 && keep_f(fb[0])) begin
      for (int i = 0; i < n; i++) push(1'b0, fb[i]);
      push(1'b1, {5'b0, !out_ready, corrupt, 1'b0});
    end
    if (open_flag) send_flag();
    send_bytes(n + 2);
    send_flag();
  endtask

  // n raw bytes, last forced zero, then seven ones
  task automatic run_abort(input int n);
    fb[n-1] = 8'h00;
    if (n - 1 >= 3 && keep_f(fb[0])) begin
      for (int i = 0; i < n - 3; i++) push(1'b0, fb[i]);
      push(1'b1, {5'b0, !out_ready, 1'b0, 1'b1});
    end
    send_flag();
    send_bytes(n);
    repeat (7) send_bit(1'b1);
    ones_run = 0;
  endtask

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_0042));
    repeat (3) @(posedge clk);
    #2;
    cur_tag = "R1";
    check(out_valid === 1'b0, "R1 reset out_valid", out_valid, 0);
    check(idle === 1'b0, "R6 reset idle", idle, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    mon_en = 1;
    check(out_valid === 1'b0 && idle === 1'b0, "R1 after reset", {out_valid, idle}, 0);

    cur_tag = "R1"; fill_rand(4); run_frame(4, 0, 1);
    cur_tag = "R1"; fill_rand(3); run_frame(3, 0, 0);      // shared flag
    cur_tag = "R2"; for (int i = 0; i < 5; i++) fb[i] = 8'hFF; run_frame(5, 0, 1);
    cur_tag = "R2"; fb[0] = 8'h7E; fb[1] = 8'hF8; fb[2] = 8'h3F; run_frame(3, 0, 1);
    cur_tag = "R4"; fill_rand(6); run_frame(6, 1, 1);
    cur_tag = "R3"; fill_rand(1); run_frame(1, 0, 1);
    cur_tag = "R7"; run_frame(0, 0, 1);
    cur_tag = "R7"; fb[0] = 8'h12; send_flag(); send_bytes(1); send_flag();
    cur_tag = "R7"; fill_rand(2); send_flag(); send_bytes(2); send_flag();

    cur_tag = "R8"; cfg_sapi_en = 3'b010; cfg_reject_on_match = 0;
    fill_rand(3); fb[0] = 8'h02; run_frame(3, 0, 1);
    fill_rand(3); fb[0] = 8'h40; run_frame(3, 0, 1);
    cfg_sapi_en = 3'b111;
    fill_rand(2); fb[0] = 8'hFC; run_frame(2, 0, 1);
    fill_rand(2); fb[0] = 8'h41; run_frame(2, 0, 1);
    fill_rand(2); fb[0] = 8'h81; run_frame(2, 0, 1);
    cfg_sapi_en = 3'b001; cfg_reject_on_match = 1;
    fill_rand(2); fb[0] = 8'hFD; run_frame(2, 0, 1);
    fill_rand(2); fb[0] = 8'h00; run_frame(2, 0, 1);
    cur_tag = "R9"; cfg_sapi_en = 3'b000;
    fill_rand(2); fb[0] = 8'hFC; run_frame(2, 0, 1);
    cfg_reject_on_match = 0;

    cur_tag = "R10"; out_ready = 0; fill_rand(4); run_frame(4, 0, 1);
    out_ready = 1;
    cur_tag = "R5"; fill_rand(6); run_abort(6);
    cur_tag = "R5"; fill_rand(3); run_abort(3);
    cur_tag = "R5"; fill_rand(2); run_frame(2, 0, 1);

    cur_tag = "R6"; send_flag();
    repeat (14) send_bit(1'b1);
    check(idle === 1'b0, "R6 idle after 14 ones", idle, 0);
    send_bit(1'b1);
    check(idle === 1'b1, "R6 idle after 15 ones", idle, 1);
    repeat (3) send_bit(1'b1);
    check(idle === 1'b1, "R6 idle holds", idle, 1);
    send_bit(1'b0);
    check(idle === 1'b0, "R6 idle cleared by zero", idle, 0);
    fill_rand(2); run_frame(2, 0, 1);

    cur_tag = "R1"; gap_en = 1;
    for (int t = 0; t < 30; t++) begin
      int n, sel;
      cfg_sapi_en = 3'($urandom);
      cfg_reject_on_match = 1'($urandom);
      out_ready = ($urandom % 4) != 0;
      n = int'($urandom % 12);
      fill_rand(n + 1);
      sel = int'($urandom % 5);
      if (sel == 0) fb[0] = 8'h00;
      else if (sel == 1) fb[0] = 8'h42;
      else if (sel == 2) fb[0] = 8'hFE;
      if ($urandom % 6 == 0) run_abort(n + 1);
      else run_frame(n, ($urandom % 4) == 0, 1);
    end
    gap_en = 0;

    repeat (20) @(posedge clk);
    #2;
    check(rd == wr, "R3 all expected beats seen", rd, wr);
    done = 1;
    summary();
    $finish;
  end
endmodule